// File: doc/BRIEF.md
# Bus-Address Wakeup and Power-History Controller

This block manages the power mode of a serially attached security peripheral. The device is always in one of four modes: active, standby, sleep, or waking. A front end outside this block decodes the serial bus. It raises a one-cycle strobe together with the device address that came straight after a start condition. The controller compares that address with a programmable address register. A hit while in standby or sleep starts a wakeup. A miss has no effect. While waking, the block refuses matching addresses with a negative acknowledge, so the host keeps polling. Once it is active, it acknowledges them and raises `ready`, which also gates command acceptance.

A 16-bit history word can be read back by the host at any time. It reads 0xFFFF after a power-on or brownout reset. It reads 0x5555 after a completed wakeup out of sleep. A processed-command strobe clears it to 0x0000, so it tells the host what happened to the device since its last command. Standby and sleep each have their own wakeup delay, given as a cycle count.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After `rst_n` is released, `chip_state` is 0xFFFF and `pwr_state` follows `cfg_init_state`. The `pwr_state` encoding is 00 active, 01 standby, 10 sleep, 11 waking. For `cfg_init_state`, 00 means active, 01 means standby, and 10 or 11 means sleep.
- R2: In standby or sleep, an `addr_evt` whose `addr_val` equals `dev_addr` moves `pwr_state` to 11 at the next edge. An `addr_evt` whose address does not match leaves the mode unchanged.
- R3: In the same cycle as a matching `addr_evt`, `addr_ack` is 1 when active and `addr_nak` is 1 in any other mode. A non-matching event raises neither. `ready` is 1 exactly when `pwr_state` is 00.
- R4: A wakeup from standby reaches active exactly `STBY_WAKE_CYC` clock edges after the edge that sampled the matching event. It leaves `chip_state` unchanged.
- R5: A wakeup from sleep reaches active exactly `SLEEP_WAKE_CYC` edges after the edge that sampled the matching event. It sets `chip_state` to 0x5555 on the same edge.
- R6: When active, a `cmd_done` pulse clears `chip_state` to 0x0000 at the next edge. When not active, `cmd_done` is ignored.
- R7: `sleep_req` and `standby_req` take effect at the next edge only from active, and `sleep_req` wins if both are present. In standby, sleep or waking they are ignored.
- R8: A matching `addr_evt` while active does not change the mode.
- R9: `brownout` overrides every other input. At the next edge it sets `chip_state` to 0xFFFF and the mode to the one chosen by `cfg_init_state`, even in the middle of a wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cfg_init_state | input | 2 | Mode entered on reset or brownout |
| dev_addr | input | ADDR_W | Programmed device address |
| addr_evt | input | 1 | Strobe: start condition followed by an address |
| addr_val | input | ADDR_W | Address carried by `addr_evt` |
| sleep_req | input | 1 | Request to enter sleep |
| standby_req | input | 1 | Request to enter standby |
| cmd_done | input | 1 | Crypto command processed |
| brownout | input | 1 | Supply interruption detected |
| pwr_state | output | 2 | Current mode |
| ready | output | 1 | Active; commands accepted |
| addr_ack | output | 1 | Acknowledge matching address |
| addr_nak | output | 1 | Refuse matching address (busy) |
| chip_state | output | 16 | Power-history word |

## Verification
`addr_ack` and `addr_nak` are combinational, so they are due in the same cycle as the strobe. Mode changes and `chip_state` updates are due one edge after the input that causes them. Wakeup completion is due `STBY_WAKE_CYC` or `SLEEP_WAKE_CYC` edges after the sampling edge. The bench drives inputs just after a rising edge and checks the combinational outputs before the next edge. It compares every output against a behavioural model on each falling edge. Directed checks count the edges until `ready` rises and compare that count with the exact figure.

// File: rtl/pwr_pkg.sv
// Package: shared mode encoding and history codes for the wakeup controller.
// Assumes a 2-bit mode field is decoded by neighbours as listed below.
package pwr_pkg;
    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'b00,
        PM_STANDBY = 2'b01,
        PM_SLEEP   = 2'b10,
        PM_WAKING  = 2'b11
    } pmode_e;

    localparam logic [15:0] HIST_POWERUP = 16'hFFFF;
    localparam logic [15:0] HIST_SLPWAKE = 16'h5555;
    localparam logic [15:0] HIST_ACTIVE  = 16'h0000;

    // Map the configuration field onto the mode entered after reset.
    function automatic pmode_e init_mode(input logic [1:0] cfg);
        pmode_e m;
        case (cfg)
            2'b00:   m = PM_ACTIVE;
            2'b01:   m = PM_STANDBY;
            default: m = PM_SLEEP;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/pwr_addr_match.sv
// Module: compares a captured bus address against the programmed one.
// Assumes addr_evt is a single-cycle strobe from the bus front end.
module pwr_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic              addr_evt,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    // Bitwise difference, one XOR per address bit.
    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
            assign diff[i] = addr_val[i] ^ dev_addr[i];
        end
    endgenerate

    // A hit needs the strobe and no differing bit.
    always_comb begin
        hit = addr_evt && (diff == '0);
    end
endmodule

// File: rtl/pwr_wake_timer.sv
// Module: down-counter timing the wakeup delay.
// Assumes both delays are at least 1. load and run never coincide.
module pwr_wake_timer #(
    parameter int STBY_WAKE_CYC  = 200,
    parameter int SLEEP_WAKE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic from_sleep,
    input  logic run,
    output logic expire
);
    localparam int MAX_CYC = (SLEEP_WAKE_CYC > STBY_WAKE_CYC) ? SLEEP_WAKE_CYC : STBY_WAKE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LD_STBY  = CNT_W'(STBY_WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_SLEEP = CNT_W'(SLEEP_WAKE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on a wake trigger, else count down while waking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= from_sleep ? LD_SLEEP : LD_STBY;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The delay has elapsed when the count is zero during a run.
    always_comb begin
        expire = run && (cnt_q == '0);
    end
endmodule

// File: rtl/pwr_chip_state.sv
// Module: 16-bit power-history register.
// Assumes its update strobes are already qualified by the mode controller.
module pwr_chip_state
    import pwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_evt,
    input  logic        slp_wake_done,
    input  logic        cmd_clr,
    output logic [15:0] value
);
    // Priority: supply event, then sleep wake completion, then command clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= HIST_POWERUP;
        end else if (pwr_evt) begin
            value <= HIST_POWERUP;
        end else if (slp_wake_done) begin
            value <= HIST_SLPWAKE;
        end else if (cmd_clr) begin
            value <= HIST_ACTIVE;
        end
    end
endmodule

// File: rtl/pwr_wake_ctrl.sv
// Module: top-level power-mode controller with address-qualified wakeup.
// Assumes synchronous inputs, a one-cycle addr_evt, and cfg_init_state
// stable around reset and brownout.
module pwr_wake_ctrl
    import pwr_pkg::*;
#(
    parameter int ADDR_W         = 7,
    parameter int STBY_WAKE_CYC  = 200,
    parameter int SLEEP_WAKE_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_init_state,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              addr_evt,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              sleep_req,
    input  logic              standby_req,
    input  logic              cmd_done,
    input  logic              brownout,
    output logic [1:0]        pwr_state,
    output logic              ready,
    output logic              addr_ack,
    output logic              addr_nak,
    output logic [15:0]       chip_state
);
    pmode_e mode_q, mode_d;
    logic   from_sleep_q, from_sleep_d;
    logic   hit, wake_load, expire;
    logic   is_active;

    pwr_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .addr_evt (addr_evt),
        .addr_val (addr_val),
        .dev_addr (dev_addr),
        .hit      (hit)
    );

    pwr_wake_timer #(
        .STBY_WAKE_CYC  (STBY_WAKE_CYC),
        .SLEEP_WAKE_CYC (SLEEP_WAKE_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wake_load),
        .from_sleep (mode_q == PM_SLEEP),
        .run        (mode_q == PM_WAKING),
        .expire     (expire)
    );

    pwr_chip_state u_hist (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_evt       (brownout),
        .slp_wake_done (!brownout && expire && from_sleep_q),
        .cmd_clr       (!brownout && is_active && cmd_done),
        .value         (chip_state)
    );

    // Decode the active mode once for the outputs and the strobes.
    always_comb begin
        is_active = (mode_q == PM_ACTIVE);
    end

    // Next-mode logic; brownout overrides every other input.
    always_comb begin
        mode_d       = mode_q;
        from_sleep_d = from_sleep_q;
        wake_load    = 1'b0;
        if (brownout) begin
            mode_d       = init_mode(cfg_init_state);
            from_sleep_d = 1'b0;
        end else begin
            case (mode_q)
                PM_ACTIVE: begin
                    if (sleep_req)        mode_d = PM_SLEEP;
                    else if (standby_req) mode_d = PM_STANDBY;
                end
                PM_STANDBY, PM_SLEEP: begin
                    if (hit) begin
                        mode_d       = PM_WAKING;
                        from_sleep_d = (mode_q == PM_SLEEP);
                        wake_load    = 1'b1;
                    end
                end
                default: begin
                    if (expire) mode_d = PM_ACTIVE;
                end
            endcase
        end
    end

    // Mode and wake-source registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= init_mode(cfg_init_state);
            from_sleep_q <= 1'b0;
        end else begin
            mode_q       <= mode_d;
            from_sleep_q <= from_sleep_d;
        end
    end

    // Port-level outputs; busy modes refuse a matching address.
    always_comb begin
        pwr_state = mode_q;
        ready     = is_active;
        addr_ack  = hit && is_active;
        addr_nak  = hit && !is_active;
    end
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
// Checker: temporal properties of pwr_wake_ctrl, attached with bind.
// Assumes the same parameters as the instance it is bound to.
module pwr_wake_ctrl_chk #(
    parameter int ADDR_W         = 7,
    parameter int STBY_WAKE_CYC  = 200,
    parameter int SLEEP_WAKE_CYC = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              addr_evt,
    input logic [ADDR_W-1:0] addr_val,
    input logic              sleep_req,
    input logic              standby_req,
    input logic              cmd_done,
    input logic              brownout,
    input logic [1:0]        pwr_state,
    input logic              ready,
    input logic              addr_ack,
    input logic              addr_nak,
    input logic [15:0]       chip_state
);
    int   wake_cnt;
    logic src_sleep;

    // Count the edges spent waking, and remember the mode the wake started from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_cnt  <= 0;
            src_sleep <= 1'b0;
        end else begin
            wake_cnt <= (pwr_state == 2'b11) ? wake_cnt + 1 : 0;
            if (pwr_state == 2'b10)      src_sleep <= 1'b1;
            else if (pwr_state == 2'b01) src_sleep <= 1'b0;
        end
    end

    a_r9_brownout_hist: assert property (@(posedge clk) disable iff (!rst_n)
        brownout |=> chip_state == 16'hFFFF);

    a_r3_ack_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_ack && addr_nak));

    a_r3_ack_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> ready && pwr_state == 2'b00);

    a_r6_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && pwr_state == 2'b00 && !brownout) |=> chip_state == 16'h0000);

    a_r2_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b01 && !brownout && !(addr_evt && addr_val == dev_addr))
            |=> pwr_state == 2'b01);

    a_r7_req_ignored_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b10 && !brownout && !addr_evt && (sleep_req || standby_req))
            |=> pwr_state == 2'b10);

    a_r8_active_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b00 && !brownout && !sleep_req && !standby_req)
            |=> pwr_state == 2'b00);

    a_r4_r5_wake_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_state) == 2'b11 && pwr_state == 2'b00 && !$past(brownout))
            |-> wake_cnt == (src_sleep ? SLEEP_WAKE_CYC : STBY_WAKE_CYC));

    a_r5_sleep_hist: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_state) == 2'b11 && pwr_state == 2'b00 && !$past(brownout) && src_sleep)
            |-> chip_state == 16'h5555);
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(
    .ADDR_W         (ADDR_W),
    .STBY_WAKE_CYC  (STBY_WAKE_CYC),
    .SLEEP_WAKE_CYC (SLEEP_WAKE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_addr    (dev_addr),
    .addr_evt    (addr_evt),
    .addr_val    (addr_val),
    .sleep_req   (sleep_req),
    .standby_req (standby_req),
    .cmd_done    (cmd_done),
    .brownout    (brownout),
    .pwr_state   (pwr_state),
    .ready       (ready),
    .addr_ack    (addr_ack),
    .addr_nak    (addr_nak),
    .chip_state  (chip_state)
);

// File: tb/tb_pwr_wake_ctrl.sv
// Bench: directed stimulus plus a behavioural reference compared every cycle.
module tb_pwr_wake_ctrl;
    localparam int AW = 7;
    localparam int SB = 5;
    localparam int SL = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg = 2'b01;
    logic [AW-1:0] dev_addr = 7'h50;
    logic          addr_evt = 1'b0;
    logic [AW-1:0] addr_val = '0;
    logic          sleep_req = 1'b0, standby_req = 1'b0, cmd_done = 1'b0, brownout = 1'b0;
    logic [1:0]    pwr_state;
    logic          ready, addr_ack, addr_nak;
    logic [15:0]   chip_state;

    int checks = 0;
    int fails  = 0;

    pwr_wake_ctrl #(.ADDR_W(AW), .STBY_WAKE_CYC(SB), .SLEEP_WAKE_CYC(SL)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_init_state(cfg), .dev_addr(dev_addr),
        .addr_evt(addr_evt), .addr_val(addr_val), .sleep_req(sleep_req),
        .standby_req(standby_req), .cmd_done(cmd_done), .brownout(brownout),
        .pwr_state(pwr_state), .ready(ready), .addr_ack(addr_ack),
        .addr_nak(addr_nak), .chip_state(chip_state)
    );

    always #4 clk = ~clk;

    // Behavioural reference model.
    int  m_mode;
    int  m_left;
    bit  m_sleep_src;
    int  m_hist;
    bit  m_hit;

    function automatic int cfg_mode(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
    endfunction

    always @(posedge clk) begin
        m_hit = addr_evt && (addr_val == dev_addr);
        if (!rst_n || brownout) begin
            m_mode <= cfg_mode(cfg);
            m_hist <= 'hFFFF;
            m_sleep_src <= 1'b0;
        end else if (m_mode == 0) begin
            if (cmd_done) m_hist <= 0;
            if (sleep_req) m_mode <= 2;
            else if (standby_req) m_mode <= 1;
        end else if (m_mode == 3) begin
            if (m_left == 1) begin
                m_mode <= 0;
                if (m_sleep_src) m_hist <= 'h5555;
            end
            m_left <= m_left - 1;
        end else if (m_hit) begin
            m_sleep_src <= (m_mode == 2);
            m_left <= (m_mode == 2) ? SL : SB;
            m_mode <= 3;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            m_hit = addr_evt && (addr_val == dev_addr);
            chk(pwr_state == m_mode[1:0], "R7 model mode", pwr_state, m_mode);
            chk(chip_state == m_hist[15:0], "R1 model history", chip_state, m_hist);
            chk(addr_ack == (m_hit && m_mode == 0), "R3 model ack", addr_ack, m_hit && m_mode == 0);
            chk(addr_nak == (m_hit && m_mode != 0), "R3 model nak", addr_nak, m_hit && m_mode != 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wake_and_count(input int exp_n, input string tag);
        int n = 0;
        addr_val = dev_addr; addr_evt = 1'b1;
        #1;
        chk(addr_nak == 1'b1 && addr_ack == 1'b0, "R3 nak while asleep", addr_nak, 1);
        tick(); addr_evt = 1'b0;
        chk(pwr_state == 2'b11, "R2 waking entered", pwr_state, 3);
        while (!ready && n < 100) begin tick(); n++; end
        chk(n == exp_n, tag, n, exp_n);
    endtask

    initial begin
        int wd = 0;
        fork
            begin
                repeat (3) tick();
                rst_n = 1'b1;
                #1;
                chk(chip_state == 16'hFFFF, "R1 reset history", chip_state, 16'hFFFF);
                chk(pwr_state == 2'b01 && !ready, "R1 reset mode standby", pwr_state, 1);
                // Mismatched address: no reply, no wake.
                addr_val = 7'h51; addr_evt = 1'b1;
                #1;
                chk(!addr_ack && !addr_nak, "R3 miss silent", {addr_ack, addr_nak}, 0);
                tick(); addr_evt = 1'b0;
                chk(pwr_state == 2'b01, "R2 miss no wake", pwr_state, 1);
                // Standby wake.
                wake_and_count(SB, "R4 standby wake length");
                chk(chip_state == 16'hFFFF, "R4 history kept", chip_state, 16'hFFFF);
                // Matching address while active.
                addr_val = dev_addr; addr_evt = 1'b1;
                #1;
                chk(addr_ack && !addr_nak, "R3 ack when active", addr_ack, 1);
                tick(); addr_evt = 1'b0;
                chk(pwr_state == 2'b00, "R8 stay active", pwr_state, 0);
                cmd_done = 1'b1; tick(); cmd_done = 1'b0;
                chk(chip_state == 16'h0000, "R6 cmd clears", chip_state, 0);
                sleep_req = 1'b1; tick(); sleep_req = 1'b0;
                chk(pwr_state == 2'b10, "R7 sleep entry", pwr_state, 2);
                standby_req = 1'b1; cmd_done = 1'b1; tick(); standby_req = 1'b0; cmd_done = 1'b0;
                chk(pwr_state == 2'b10, "R7 standby ignored in sleep", pwr_state, 2);
                chk(chip_state == 16'h0000, "R6 cmd ignored asleep", chip_state, 0);
                // Sleep wake with requests during waking.
                addr_val = dev_addr; addr_evt = 1'b1; tick(); addr_evt = 1'b0;
                sleep_req = 1'b1; tick(); sleep_req = 1'b0;
                chk(pwr_state == 2'b11, "R7 req ignored waking", pwr_state, 3);
                repeat (SL - 2) tick();
                chk(!ready, "R5 not early", ready, 0);
                tick();
                chk(ready && chip_state == 16'h5555, "R5 sleep wake history", chip_state, 16'h5555);
                // Both requests: sleep wins.
                sleep_req = 1'b1; standby_req = 1'b1; tick(); sleep_req = 1'b0; standby_req = 1'b0;
                chk(pwr_state == 2'b10, "R7 sleep priority", pwr_state, 2);
                wake_and_count(SL, "R5 sleep wake length");
                // New address and standby path again.
                standby_req = 1'b1; tick(); standby_req = 1'b0;
                dev_addr = 7'h2A;
                wake_and_count(SB, "R4 second standby wake");
                // Brownout mid-wake, cfg now sleep.
                sleep_req = 1'b1; tick(); sleep_req = 1'b0;
                cfg = 2'b10;
                addr_val = dev_addr; addr_evt = 1'b1; tick(); addr_evt = 1'b0;
                tick(); tick();
                brownout = 1'b1; tick(); brownout = 1'b0;
                chk(pwr_state == 2'b10, "R9 brownout mode", pwr_state, 2);
                chk(chip_state == 16'hFFFF, "R9 brownout history", chip_state, 16'hFFFF);
                cfg = 2'b00;
                brownout = 1'b1; cmd_done = 1'b1; tick(); brownout = 1'b0; cmd_done = 1'b0;
                chk(pwr_state == 2'b00 && chip_state == 16'hFFFF, "R9 brownout over cmd", chip_state, 16'hFFFF);
                tick();
            end
            begin
                while (wd < 5000) begin @(posedge clk); wd++; end
                chk(1'b0, "R1 watchdog", wd, 0);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule